// File: doc/BRIEF.md
# Index Pointer Update Unit with Wrap and Reverse-Carry Modes

This block computes the memory address for one indexed access and the new value of the index pointer. Each request supplies the current index, a modifier, a buffer base and a buffer length, together with three option bits. These select pre-modify or post-modify, circular wrapping, and reverse-carry addition. One clock after a request, the block presents two values at once: the address of the access, and the updated pointer with a write strobe that lets the surrounding pointer register store it. The access and the pointer write-back therefore fall in the same cycle.

Four kinds of update are supported. The plain update adds the modifier, taken as a full-width two's-complement value, to the index. The circular update adds the modifier and then folds the sum back into the window that starts at the base and spans the length. The reverse-carry update adds the modifier while the carries ripple from the most significant bit down toward bit 0, which steps an index through bit-reversed order for FFT data shuffles. A parameter can leave the reverse-carry adder out of the build.

Top module: `agu_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ptr_we`, `acc_addr` and `ptr_upd` are all zero.
- R2: `ptr_we` is high in the cycle after `req_valid` is sampled high, and low in the cycle after it is sampled low. A cycle without a request leaves `acc_addr` and `ptr_upd` unchanged.
- R3: With `req_pre` = 0 (post-modify), `acc_addr` equals the index as it was at the request, and `ptr_upd` carries the modified index.
- R4: With `req_pre` = 1 (pre-modify), `acc_addr` and `ptr_upd` both equal the modified index.
- R5: With `req_circ` = 0 and `req_brev` = 0, the modified index is `cur_index + cur_modifier` modulo 2^32. The modifier is a full 32-bit two's-complement value, so 0xFFFFFFF8 steps back by 8.
- R6: In circular mode (`req_circ` = 1, `req_brev` = 0, `cur_length` != 0), a sum at or above `cur_base + cur_length` has `cur_length` subtracted from it.
- R7: In circular mode, a sum below `cur_base` has `cur_length` added to it. A sum inside the window is passed through unchanged.
- R8: With `cur_length` = 0, `req_circ` has no effect and the update is the plain sum of R5.
- R9: With `req_brev` = 1, the modified index is the sum of index and modifier with the carry running from bit 31 toward bit 0. For example, with modifier 4 the index goes 0, 4, 2, 6, 1.
- R10: When `req_brev` and `req_circ` are both 1, the reverse-carry update of R9 is used and no circular folding takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_pre | input | 1 | 1: pre-modify, 0: post-modify |
| req_circ | input | 1 | Request circular wrapping |
| req_brev | input | 1 | Request reverse-carry update |
| cur_index | input | 32 | Current pointer value |
| cur_modifier | input | 32 | Two's-complement step |
| cur_base | input | 32 | Start of the circular window |
| cur_length | input | 32 | Size of the circular window, 0 turns wrapping off |
| acc_addr | output | 32 | Address of the access |
| ptr_upd | output | 32 | Updated pointer value |
| ptr_we | output | 1 | Write strobe for the pointer register |

## Verification
The hardest cases to reach are the two folding boundaries of the circular window. These are a sum that lands exactly on `base + length`, and a negative modifier that carries the sum just below the base. Reaching them needs chosen pairs of index and modifier with a negative two's-complement step, rather than random values. The reverse-carry order only shows itself over a chain of accesses, so the stimulus feeds each updated pointer back as the next index and compares the whole 0, 4, 2, 6, 1 walk. A request with both modes set, on a window small enough that folding would alter the result, separates the priority rule from plain reverse-carry behaviour.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      UPD_LINEAR = 2'd0,
      UPD_CIRC   = 2'd1,
      UPD_BREV   = 2'd2
   } upd_kind_e;

   // reverse-carry has priority; an empty window falls back to linear
   function automatic upd_kind_e pick_kind(input logic circ, input logic brev,
                                           input logic len_zero, input logic brev_ok);
      if (brev && brev_ok)
         return UPD_BREV;
      else if (circ && !len_zero)
         return UPD_CIRC;
      else
         return UPD_LINEAR;
   endfunction

endpackage

// File: rtl/agu_brev_add.sv
module agu_brev_add #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] a_in,
   input  logic [AW-1:0] b_in,
   output logic [AW-1:0] sum_out
);
   logic [AW-1:0] ra, rb, rs;

   // mirror operands, add normally, mirror back: carries run MSB -> LSB
   for (genvar i = 0; i < AW; i++) begin : g_mirror
      assign ra[i]      = a_in[AW-1-i];
      assign rb[i]      = b_in[AW-1-i];
      assign sum_out[i] = rs[AW-1-i];
   end

   assign rs = ra + rb;

endmodule

// File: rtl/agu_circ_upd.sv
module agu_circ_upd #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] index_in,
   input  logic [AW-1:0] mod_in,
   input  logic [AW-1:0] base_in,
   input  logic [AW-1:0] len_in,
   output logic [AW-1:0] wrap_out
);
   localparam int EW = AW + 2;

   logic signed [EW-1:0] sum_w, base_w, len_w, lim_w, res_w;

   always_comb begin
      sum_w  = $signed({2'b00, index_in}) + $signed({{2{mod_in[AW-1]}}, mod_in});
      base_w = $signed({2'b00, base_in});
      len_w  = $signed({2'b00, len_in});
      lim_w  = base_w + len_w;
      if (sum_w >= lim_w)
         res_w = sum_w - len_w;
      else if (sum_w < base_w)
         res_w = sum_w + len_w;
      else
         res_w = sum_w;
      wrap_out = res_w[AW-1:0];
   end

endmodule

// File: rtl/agu_core.sv
module agu_core #(
   parameter int AW           = 32,
   parameter bit BREV_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_pre,
   input  logic          req_circ,
   input  logic          req_brev,
   input  logic [AW-1:0] cur_index,
   input  logic [AW-1:0] cur_modifier,
   input  logic [AW-1:0] cur_base,
   input  logic [AW-1:0] cur_length,
   output logic [AW-1:0] acc_addr,
   output logic [AW-1:0] ptr_upd,
   output logic          ptr_we
);
   import agu_pkg::*;

   if (AW < 8) begin : g_bad_width
      $error("agu_core: AW must be at least 8");
   end

   logic [AW-1:0] lin_sum, circ_sum, brev_sum, next_ptr, next_addr;
   upd_kind_e     kind;

   assign lin_sum = cur_index + cur_modifier;

   agu_circ_upd #(.AW(AW)) u_circ (
      .index_in (cur_index),
      .mod_in   (cur_modifier),
      .base_in  (cur_base),
      .len_in   (cur_length),
      .wrap_out (circ_sum)
   );

   if (BREV_SUPPORT) begin : g_brev
      agu_brev_add #(.AW(AW)) u_brev (
         .a_in    (cur_index),
         .b_in    (cur_modifier),
         .sum_out (brev_sum)
      );
   end else begin : g_no_brev
      assign brev_sum = lin_sum;
   end

   always_comb begin
      kind = pick_kind(req_circ, req_brev, (cur_length == '0), BREV_SUPPORT);
      unique case (kind)
         UPD_BREV: next_ptr = brev_sum;
         UPD_CIRC: next_ptr = circ_sum;
         default:  next_ptr = lin_sum;
      endcase
      next_addr = req_pre ? next_ptr : cur_index;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_we   <= 1'b0;
         acc_addr <= '0;
         ptr_upd  <= '0;
      end else begin
         ptr_we <= req_valid;
         if (req_valid) begin
            acc_addr <= next_addr;
            ptr_upd  <= next_ptr;
         end
      end
   end

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_pre,
   input logic          req_circ,
   input logic          req_brev,
   input logic [AW-1:0] cur_index,
   input logic [AW-1:0] cur_modifier,
   input logic [AW-1:0] cur_length,
   input logic [AW-1:0] acc_addr,
   input logic [AW-1:0] ptr_upd,
   input logic          ptr_we
);
   // R1
   reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (!ptr_we && acc_addr == '0 && ptr_upd == '0));

   // R2
   we_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> ptr_we);

   // R2
   no_req_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !ptr_we);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(acc_addr) && $stable(ptr_upd)));

   // R3
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_pre) |=> acc_addr == $past(cur_index));

   // R4
   pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_pre) |=> acc_addr == ptr_upd);

   // R5 / R8
   linear_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_brev && (!req_circ || cur_length == '0))
         |=> ptr_upd == $past(cur_index + cur_modifier));

endmodule

bind agu_core agu_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_pre      (req_pre),
   .req_circ     (req_circ),
   .req_brev     (req_brev),
   .cur_index    (cur_index),
   .cur_modifier (cur_modifier),
   .cur_length   (cur_length),
   .acc_addr     (acc_addr),
   .ptr_upd      (ptr_upd),
   .ptr_we       (ptr_we)
);

// File: tb/sim_agu_core.sv
module sim_agu_core;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_pre = 1'b0, req_circ = 1'b0, req_brev = 1'b0;
   logic [AW-1:0] cur_index = '0, cur_modifier = '0, cur_base = '0, cur_length = '0;
   logic [AW-1:0] acc_addr, ptr_upd;
   logic          ptr_we;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [AW-1:0] addr;
      logic [AW-1:0] ptr;
      string         tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   agu_core #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pre(req_pre),
      .req_circ(req_circ), .req_brev(req_brev), .cur_index(cur_index),
      .cur_modifier(cur_modifier), .cur_base(cur_base), .cur_length(cur_length),
      .acc_addr(acc_addr), .ptr_upd(ptr_upd), .ptr_we(ptr_we)
   );

   function automatic logic [AW-1:0] ref_brev(input logic [AW-1:0] a, input logic [AW-1:0] b);
      logic [AW-1:0] r;
      logic c;
      c = 1'b0;
      for (int i = AW - 1; i >= 0; i--) begin
         r[i] = a[i] ^ b[i] ^ c;
         c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      end
      return r;
   endfunction

   function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] idx, input logic [AW-1:0] m,
                                              input logic [AW-1:0] base, input logic [AW-1:0] len,
                                              input logic circ, input logic brev);
      longint s, lo, hi;
      if (brev) return ref_brev(idx, m);
      s = longint'(idx) + longint'($signed(m));
      if (circ && len != 0) begin
         lo = longint'(base);
         hi = lo + longint'(len);
         if (s >= hi) s = s - longint'(len);
         else if (s < lo) s = s + longint'(len);
      end
      return s[AW-1:0];
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input string tag, input logic [AW-1:0] idx, input logic [AW-1:0] m,
                        input logic [AW-1:0] base, input logic [AW-1:0] len,
                        input logic circ, input logic brev, input logic pre,
                        output logic [AW-1:0] nxt);
      exp_t e;
      @(negedge clk);
      nxt = ref_next(idx, m, base, len, circ, brev);
      e.ptr  = nxt;
      e.addr = pre ? nxt : idx;
      e.tag  = tag;
      sb.push_back(e);
      req_valid = 1'b1; req_pre = pre; req_circ = circ; req_brev = brev;
      cur_index = idx; cur_modifier = m; cur_base = base; cur_length = len;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      cur_index = 32'hDEAD_BEEF; cur_modifier = 32'h1234_5678;
   endtask

   // monitor: pops the scoreboard whenever a write-back appears
   always @(negedge clk) begin
      if (rst_n && ptr_we) begin
         if (sb.size() == 0) begin
            check("R2 unexpected ptr_we", {31'd0, ptr_we}, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " addr"}, acc_addr, e.addr);
            check({e.tag, " ptr"}, ptr_upd, e.ptr);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] n, p;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ptr_we", {31'd0, ptr_we}, '0);
      check("R1 acc_addr", acc_addr, '0);
      check("R1 ptr_upd", ptr_upd, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ptr_we after release", {31'd0, ptr_we}, '0);

      // R3 + R5 post-modify linear
      issue("R3 R5 post +4", 32'd100, 32'd4, '0, '0, 1'b0, 1'b0, 1'b0, n);
      // R4 + R5 pre-modify, negative step
      issue("R4 R5 pre -8", 32'd100, 32'hFFFF_FFF8, '0, '0, 1'b0, 1'b0, 1'b1, n);
      // R5 full-range wrap of the sum
      issue("R5 wrap top", 32'hFFFF_FFFF, 32'd1, '0, '0, 1'b0, 1'b0, 1'b0, n);
      issue("R5 big neg", 32'h0000_0010, 32'hFFFF_FFF0, '0, '0, 1'b0, 1'b0, 1'b1, n);
      // R6 circular upper fold, exact boundary
      issue("R6 upper edge", 32'h20C, 32'd4, 32'h200, 32'd16, 1'b1, 1'b0, 1'b1, n);
      issue("R6 upper over", 32'h20E, 32'd5, 32'h200, 32'd16, 1'b1, 1'b0, 1'b0, n);
      // R7 circular lower fold and in-window
      issue("R7 lower", 32'h201, 32'hFFFF_FFFD, 32'h200, 32'd16, 1'b1, 1'b0, 1'b1, n);
      issue("R7 inside", 32'h204, 32'd4, 32'h200, 32'd16, 1'b1, 1'b0, 1'b0, n);
      // R8 zero length
      issue("R8 len zero", 32'h20C, 32'd8, 32'h200, 32'd0, 1'b1, 1'b0, 1'b1, n);
      // R10 both modes: reverse-carry wins (4 -> 2, folding would give 5)
      issue("R10 priority", 32'd4, 32'd4, 32'd0, 32'd3, 1'b1, 1'b1, 1'b1, n);

      // R2 idle: ptr_we drops, outputs hold
      idle();
      @(negedge clk);
      check("R2 idle ptr_we", {31'd0, ptr_we}, '0);
      p = ptr_upd;
      @(negedge clk);
      check("R2 hold ptr_upd", ptr_upd, p);
      check("R2 hold ptr_upd value", ptr_upd, 32'd2);

      // R9 reverse-carry chain fed back: 0,4,2,6,1
      p = '0;
      for (int k = 0; k < 4; k++) begin
         issue("R9 chain", p, 32'd4, '0, '0, 1'b0, 1'b1, 1'b1, n);
         p = n;
      end
      check("R9 chain end", p, 32'd1);
      issue("R9 post", 32'd6, 32'd4, '0, '0, 1'b0, 1'b1, 1'b0, n);
      idle();
      repeat (3) @(negedge clk);
      check("R2 scoreboard drained", 32'(sb.size()), '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule